// File: doc/BRIEF.md
# Signed Array Multiplier

This block multiplies two two's-complement operands of a parameterised width `N` (8 by default) and returns the full `2N`-bit signed product. The arithmetic core is a grid of AND-gated full-adder cells arranged in `N` rows. Each row adds the multiplicand, shifted one more place to the left, into the running partial product when its multiplier bit is set. A row whose multiplier bit is clear passes the running sum through unchanged.

Signed operation comes from a conditioning stage placed in front of the grid. A negative multiplier causes both operands to be negated, so the grid only ever sees a non-negative multiplier. The negation uses `N+1` bits, so the most negative multiplier value becomes a true positive number. The conditioned multiplicand is sign-extended across the whole `2N`-bit width, so every partial product it contributes carries its sign.

Operands enter on a valid/ready stream and the product leaves on another. A product is registered on every accepted transfer and offered on the output stream on the next cycle. While the output is stalled, the result is held and no new operand pair is taken. Back-pressure passes straight through: `in_ready` is high whenever the output register is empty or is being drained in the same cycle.

Top module: `smul_stream`

## Requirements
- R1: For every operand pair, the product presented is the signed product of `in_mcand` and `in_mplier`, both read as two's-complement `N`-bit numbers, as a `2N`-bit two's-complement value.
- R2: If either operand is zero, the product is all zeros.
- R3: A multiplier of `2^(N-1)` as an unsigned pattern (the most negative value, only the top bit set) gives the correct product. In particular, most-negative times most-negative gives `+2^(2N-2)`.
- R4: A negative multiplicand with a positive multiplier gives the sign-extended negative product. For example, with `N = 5`, `5'h13` (−13) times `5'h0B` (+11) gives `10'h371` (−143).
- R5: A negative multiplier gives the same product as negating both operands. Internally, the multiplier presented to the adder grid is never negative.
- R6: When both operands are non-zero, the top product bit equals the XOR of the two operand sign bits.
- R7: A transfer is accepted on a rising edge where `in_valid` and `in_ready` are both high. `out_valid` is high after that edge, with the product of the accepted pair.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_product` stays unchanged and `in_ready` is low.
- R9: During and just after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take an operand pair |
| in_mcand | input | N | Multiplicand, two's complement |
| in_mplier | input | N | Multiplier, two's complement |
| out_valid | output | 1 | Product register holds a result |
| out_ready | input | 1 | Consumer takes the product |
| out_product | output | 2N | Signed product |

## Verification
The hardest case to reach is the most negative multiplier. After negation it still looks negative at `N` bits, so it only works because the conditioning stage widens to `N+1` bits. An exhaustive sweep of all 1024 pairs at `N = 5` drives every such combination, including most-negative times itself. Directed vectors at `N = 8` hit the same corners before a random sweep. The stall case is reached by lowering `out_ready` while a second pair waits on the input stream. The bench then checks that the first product is held and that the waiting pair is taken only after the stall is released.

// File: rtl/smul_pkg.sv
package smul_pkg;
  // one-bit full adder, sum output
  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  // one-bit full adder, carry output
  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (c & (a ^ b));
  endfunction
endpackage

// File: rtl/smul_cell.sv
module smul_cell
  import smul_pkg::*;
(
  input  logic m_bit,
  input  logic q_bit,
  input  logic pp_in,
  input  logic c_in,
  output logic sum,
  output logic c_out
);
  logic gated;
  assign gated = m_bit & q_bit;
  assign sum   = fa_sum(pp_in, gated, c_in);
  assign c_out = fa_carry(pp_in, gated, c_in);
endmodule

// File: rtl/smul_precond.sv
module smul_precond #(
  parameter int N = 8
) (
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic [2*N-1:0] mcand_ext,
  output logic [N-1:0]   mplier_mag
);
  localparam int W = 2 * N;

  logic [N:0] a_w;
  logic [N:0] b_w;

  always_comb begin
    a_w = {mcand[N-1], mcand};
    b_w = {mplier[N-1], mplier};
    if (mplier[N-1]) begin
      a_w = (~a_w) + 1'b1;
      b_w = (~b_w) + 1'b1;
    end
    mplier_mag = b_w[N-1:0];
    mcand_ext  = {{(W-N-1){a_w[N]}}, a_w};
    // R5: after conditioning, the multiplier fed to the grid is never negative
    assert_mplier_nonneg_R5: assert (b_w[N] == 1'b0);
  end
endmodule

// File: rtl/smul_array.sv
module smul_array #(
  parameter int N = 8
) (
  input  logic [2*N-1:0] mcand_ext,
  input  logic [N-1:0]   mplier_mag,
  output logic [2*N-1:0] product
);
  localparam int W = 2 * N;

  logic [W-1:0] pp [N+1];

  assign pp[0] = '0;

  for (genvar r = 0; r < N; r++) begin : g_row
    logic [W-1:0] addend;
    logic [W-1:0] carry;
    logic [W-1:0] row_sum;

    assign addend   = mcand_ext << r;
    assign carry[0] = 1'b0;

    for (genvar c = 0; c < W - 1; c++) begin : g_col
      smul_cell u_cell (
        .m_bit (addend[c]),
        .q_bit (mplier_mag[r]),
        .pp_in (pp[r][c]),
        .c_in  (carry[c]),
        .sum   (row_sum[c]),
        .c_out (carry[c+1])
      );
    end

    // top column: its carry leaves the 2N-bit range, so only the sum is kept
    assign row_sum[W-1] = pp[r][W-1] ^ (addend[W-1] & mplier_mag[r]) ^ carry[W-1];
    assign pp[r+1]      = row_sum;
  end

  assign product = pp[N];
endmodule

// File: rtl/smul_stream.sv
module smul_stream #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N-1:0]   in_mcand,
  input  logic [N-1:0]   in_mplier,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*N-1:0] out_product
);
  localparam int W = 2 * N;
  localparam logic [W-1:0] MIN_SQ = W'(1) << (W - 2);
  localparam logic [N-1:0] MIN_OP = N'(1) << (N - 1);

  logic [W-1:0] mcand_ext;
  logic [N-1:0] mplier_mag;
  logic [W-1:0] comb_product;
  logic         accept;

  smul_precond #(.N(N)) u_precond (
    .mcand      (in_mcand),
    .mplier     (in_mplier),
    .mcand_ext  (mcand_ext),
    .mplier_mag (mplier_mag)
  );

  smul_array #(.N(N)) u_array (
    .mcand_ext  (mcand_ext),
    .mplier_mag (mplier_mag),
    .product    (comb_product)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_product <= '0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_product <= comb_product;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  // R7: an accepted pair is presented on the next cycle
  assert_accept_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R8: a stalled product is held
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_product)));

  // R8: no new pair is taken while stalled
  assert_stall_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R2: zero operand gives zero product
  assert_zero_product_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_mcand == '0 || in_mplier == '0)) |=> (out_product == '0));

  // R6: sign of product follows operand signs
  assert_product_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_mcand != '0 && in_mplier != '0)
      |=> (out_product[W-1] == ($past(in_mcand[N-1]) ^ $past(in_mplier[N-1]))));

  // R3: most negative squared
  assert_min_square_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_mcand == MIN_OP && in_mplier == MIN_OP) |=> (out_product == MIN_SQ));
endmodule

// File: tb/smul_stream_tb_top.sv
module smul_stream_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // N = 8 instance
  logic        v8 = 1'b0, r8, ov8, or8 = 1'b1;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] p8;

  smul_stream #(.N(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(v8), .in_ready(r8),
    .in_mcand(a8), .in_mplier(b8), .out_valid(ov8), .out_ready(or8),
    .out_product(p8)
  );

  // N = 5 instance
  logic        v5 = 1'b0, r5, ov5, or5 = 1'b1;
  logic [4:0]  a5 = '0, b5 = '0;
  logic [9:0]  p5;

  smul_stream #(.N(5)) dut_n5_i (
    .clk(clk), .rst_n(rst_n), .in_valid(v5), .in_ready(r5),
    .in_mcand(a5), .in_mplier(b5), .out_valid(ov5), .out_ready(or5),
    .out_product(p5)
  );

  // {multiplicand, multiplier, expected product} for N = 8
  localparam logic [31:0] VEC [12] = '{
    {8'h00, 8'h37, 16'h0000},  // R2
    {8'h05, 8'h03, 16'h000F},  // R1
    {8'hFF, 8'h01, 16'hFFFF},  // R4
    {8'h01, 8'hFF, 16'hFFFF},  // R5
    {8'hFF, 8'hFF, 16'h0001},  // R5
    {8'h80, 8'h80, 16'h4000},  // R3
    {8'h80, 8'h7F, 16'hC080},  // R4
    {8'h7F, 8'h80, 16'hC080},  // R3
    {8'h7F, 8'h7F, 16'h3F01},  // R1
    {8'h80, 8'hFF, 16'h0080},  // R5
    {8'hF3, 8'h0B, 16'hFF71},  // R4
    {8'h0B, 8'hF3, 16'hFF71}   // R6
  };

  function automatic logic [15:0] ref8(input logic [7:0] a, input logic [7:0] b);
    logic signed [15:0] sa, sb;
    sa = $signed(a);
    sb = $signed(b);
    return 16'(sa * sb);
  endfunction

  function automatic logic [9:0] ref5(input logic [4:0] a, input logic [4:0] b);
    logic signed [9:0] sa, sb;
    sa = $signed(a);
    sb = $signed(b);
    return 10'(sa * sb);
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply8(input logic [7:0] a, input logic [7:0] b,
                        input logic [15:0] exp, input string req);
    @(negedge clk);
    a8 = a; b8 = b; v8 = 1'b1;
    @(negedge clk);
    v8 = 1'b0;
    check(ov8 && p8 == exp, req, p8, exp);
  endtask

  task automatic apply5(input logic [4:0] a, input logic [4:0] b,
                        input logic [9:0] exp, input string req);
    @(negedge clk);
    a5 = a; b5 = b; v5 = 1'b1;
    @(negedge clk);
    v5 = 1'b0;
    check(ov5 && p5 == exp, req, {6'd0, p5}, {6'd0, exp});
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!ov8 && r8, "R9 during reset", {14'd0, ov8, r8}, 16'h0001);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ov8 && r8 && !ov5 && r5, "R9 after reset", {14'd0, ov8, r8}, 16'h0001);

    // table walk, R1..R6
    foreach (VEC[i]) apply8(VEC[i][31:24], VEC[i][23:16], VEC[i][15:0], "R1 table");

    // R4: the 5-bit case -13 x +11 = -143
    apply5(5'h13, 5'h0B, 10'h371, "R4 -13x11");
    // R3: most negative squared at 5 bits
    apply5(5'h10, 5'h10, 10'h100, "R3 min squared");

    // R1/R5/R6: exhaustive sweep at N = 5
    for (int x = 0; x < 32; x++)
      for (int y = 0; y < 32; y++)
        apply5(5'(x), 5'(y), ref5(5'(x), 5'(y)), "R1 exhaustive n5");

    // R1: random sweep at N = 8
    for (int k = 0; k < 2000; k++) begin
      logic [7:0] ra, rb;
      ra = 8'($urandom);
      rb = 8'($urandom);
      apply8(ra, rb, ref8(ra, rb), "R1 random n8");
    end

    // R7/R8: stall with a second pair waiting
    @(negedge clk);
    or8 = 1'b0;
    a8 = 8'hF3; b8 = 8'h0B; v8 = 1'b1;
    @(negedge clk);
    check(ov8 && p8 == 16'hFF71, "R7 accept", p8, 16'hFF71);
    a8 = 8'h09; b8 = 8'hF9;        // -63 expected later
    check(!r8, "R8 in_ready low", {15'd0, r8}, 16'h0000);
    repeat (2) @(negedge clk);
    check(ov8 && p8 == 16'hFF71, "R8 hold", p8, 16'hFF71);
    or8 = 1'b1;
    @(negedge clk);
    v8 = 1'b0;
    check(ov8 && p8 == 16'hFFC1, "R7 next after stall", p8, 16'hFFC1);
    @(negedge clk);
    check(!ov8, "R7 drained", {15'd0, ov8}, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule